// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block collects per-channel event pulses from a multi-channel DMA engine, records them in per-channel status registers and merges them into one interrupt line. Each channel has two independent masks. The status-enable mask decides which events are recorded. The signal-enable mask decides which recorded events reach the interrupt line. An event can therefore be logged for polling, for example a channel reaching its suspended state, without waking the processor.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a word address and combinational read data.

The address map uses word addresses:

- Word 0 is the common configuration register. Bit 0 is the global interrupt enable.
- Channel `c` occupies words `4+4c` to `7+4c`, at these offsets:
  - +0: status (read only).
  - +1: status-enable.
  - +2: signal-enable.
  - +3: write-one-to-clear.

Event bit `i` of channel `c` arrives on `evt_i[c*EVT_W+i]` and lands in status bit `i` of that channel. By convention, bit 0 is transfer-done, bit 1 is suspended and the higher bits are error causes. The block treats all bits alike.

Top module: `dma_irq_ctrl`

## Requirements
- R1: An event bit sets its status bit at the next clock edge only when the matching status-enable bit is 1. With a status-enable value of zero, no event of that channel is recorded.
- R2: A set status bit drives the interrupt only when its signal-enable bit is 1. A status bit (such as suspended, bit 1) with signal-enable 0 stays recorded while `irq_o` stays low.
- R3: Writing the clear word (offset +3) clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R4: When global enable (word 0, bit 0) is 0, `irq_o` is low one cycle later, and all status registers keep their contents.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit is set after the edge.
- R6: `irq_o` is registered. It equals the global enable AND the OR over all channels of (status AND signal-enable), as those values stood one cycle earlier.
- R7: After reset, every status, status-enable and signal-enable register, the global enable and `irq_o` are zero.
- R8: The status, status-enable, signal-enable and configuration words read back their contents in the low bits, with zero above. The clear word and unmapped words read zero. Writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CH*EVT_W | Event pulses, EVT_W bits per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench goes after three collisions:

- **Event against clear on the same bit.** A design where the clear wins would lose the event.
- **Recorded but unsignalled bits.** A design that ORs status without the signal-enable mask would raise the line for a suspended-only channel.
- **Global disable.** A design that clears status on disable, instead of only gating the line, would lose pending causes.

It also checks the one-cycle latency of `irq_o`, so an unregistered or doubly registered output shows up. A long mixed sweep with a cycle model catches a channel decode error: a write landing in the wrong channel or at the wrong offset.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NUM_CH = 4,
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*EVT_W-1:0] evt_i,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    irq_o
);
  localparam int TOT     = NUM_CH * EVT_W;
  localparam int CH_BASE = 4;

  logic           gen;
  logic [TOT-1:0] st, sten, sien;

  always_ff @(posedge clk) begin
    if (!rst_n)                         gen <= 1'b0;
    else if (reg_we && reg_addr == '0)  gen <= reg_wdata[0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A = ADDR_W'(CH_BASE + 4*c);
    logic [EVT_W-1:0] clr;
    assign clr = (reg_we && reg_addr == A + ADDR_W'(3)) ? reg_wdata[EVT_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[c*EVT_W +: EVT_W]   <= '0;
        sten[c*EVT_W +: EVT_W] <= '0;
        sien[c*EVT_W +: EVT_W] <= '0;
      end else begin
        if (reg_we && reg_addr == A + ADDR_W'(1)) sten[c*EVT_W +: EVT_W] <= reg_wdata[EVT_W-1:0];
        if (reg_we && reg_addr == A + ADDR_W'(2)) sien[c*EVT_W +: EVT_W] <= reg_wdata[EVT_W-1:0];
        st[c*EVT_W +: EVT_W] <= (st[c*EVT_W +: EVT_W] & ~clr)
                              | (evt_i[c*EVT_W +: EVT_W] & sten[c*EVT_W +: EVT_W]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata[0] = gen;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(CH_BASE + 4*c))     reg_rdata[EVT_W-1:0] = st[c*EVT_W +: EVT_W];
      if (reg_addr == ADDR_W'(CH_BASE + 4*c + 1)) reg_rdata[EVT_W-1:0] = sten[c*EVT_W +: EVT_W];
      if (reg_addr == ADDR_W'(CH_BASE + 4*c + 2)) reg_rdata[EVT_W-1:0] = sien[c*EVT_W +: EVT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gen & |(st & sien);
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int TOT = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TOT-1:0] evt_i,
  input logic           reg_we,
  input logic [TOT-1:0] st,
  input logic [TOT-1:0] sten,
  input logic [TOT-1:0] sien,
  input logic           gen,
  input logic           irq_o
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & $past(evt_i & sten)) == $past(evt_i & sten)));

  p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(evt_i & sten)) == '0));

  p_sigmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(st & sien)));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gen));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((st & $past(st)) == $past(st)));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.TOT(NUM_CH*EVT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
  .st(st), .sten(sten), .sien(sien), .gen(gen), .irq_o(irq_o)
);

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  localparam int NCH = 4, EW = 8, AW = 8;

  logic          clk = 0, rst_n = 0;
  logic [NCH*EW-1:0] evt = '0;
  logic          we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          irq;

  int vecs = 0, errs = 0;
  logic [EW-1:0] m_st [NCH], m_sten [NCH], m_sien [NCH];
  logic m_gen, m_irq;

  always #4 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH), .EVT_W(EW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  initial begin
    #1500000;
    errs++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  task automatic mreset();
    for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_sten[c] = 0; m_sien[c] = 0; end
    m_gen = 0; m_irq = 0;
  endtask

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    logic [31:0] r = 0;
    if (a == 0) r[0] = m_gen;
    for (int c = 0; c < NCH; c++) begin
      if (a == AW'(4+4*c)) r[EW-1:0] = m_st[c];
      if (a == AW'(5+4*c)) r[EW-1:0] = m_sten[c];
      if (a == AW'(6+4*c)) r[EW-1:0] = m_sien[c];
    end
    return r;
  endfunction

  task automatic cyc(logic w, logic [AW-1:0] a, logic [31:0] d, logic [NCH*EW-1:0] e);
    logic any = 0;
    we = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    for (int c = 0; c < NCH; c++) any |= |(m_st[c] & m_sien[c]);
    m_irq = m_gen & any;
    for (int c = 0; c < NCH; c++) begin
      logic [EW-1:0] clr = (w && a == AW'(7+4*c)) ? d[EW-1:0] : '0;
      m_st[c] = (m_st[c] & ~clr) | (e[c*EW +: EW] & m_sten[c]);
      if (w && a == AW'(5+4*c)) m_sten[c] = d[EW-1:0];
      if (w && a == AW'(6+4*c)) m_sien[c] = d[EW-1:0];
    end
    if (w && a == 0) m_gen = d[0];
    @(negedge clk);
    we = 0; evt = '0;
  endtask

  task automatic chk_irq(string tag);
    vecs++;
    if (irq !== m_irq) begin
      errs++;
      $display("FAIL %s: irq_o got %0b expected %0b", tag, irq, m_irq);
    end
  endtask

  task automatic chk_rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    vecs++;
    if (rdata !== exp) begin
      errs++;
      $display("FAIL %s: addr %0d read got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 22; a++) chk_rd(AW'(a), 32'h0, "R7 reset value");
    chk_irq("R7 reset irq");

    cyc(1, 0, 1, '0);
    cyc(0, 0, 0, '1);
    chk_rd(4, 0, "R1 zero status-enable records nothing");

    cyc(1, 5, 32'h03, '0);
    cyc(1, 6, 32'h01, '0);
    cyc(0, 0, 0, 32'h02);
    chk_rd(4, 32'h02, "R2 suspended recorded");
    cyc(0, 0, 0, '0);
    chk_irq("R2 unsignalled bit keeps irq low");
    if (irq !== 1'b0) begin errs++; $display("FAIL R2: irq got 1 expected 0"); end
    vecs++;

    cyc(0, 0, 0, 32'h01);
    chk_rd(4, 32'h03, "R1 enabled event recorded");
    chk_irq("R6 irq not yet high");
    cyc(0, 0, 0, '0);
    chk_irq("R6 irq one cycle after status");
    vecs++;
    if (irq !== 1'b1) begin errs++; $display("FAIL R6: irq got 0 expected 1"); end

    cyc(1, 0, 0, '0);
    chk_irq("R4 global disable");
    chk_rd(4, 32'h03, "R4 status kept while disabled");
    cyc(1, 0, 1, '0);

    cyc(1, 7, 32'h0, '0);
    chk_rd(4, 32'h03, "R3 zero clear leaves bits");
    cyc(1, 7, 32'h01, '0);
    chk_rd(4, 32'h02, "R3 one clears bit");
    chk_rd(7, 32'h0, "R8 clear word reads zero");
    cyc(1, 4, 32'hFF, '0);
    chk_rd(4, 32'h02, "R8 status write ignored");

    cyc(1, 7, 32'h02, 32'h02);
    chk_rd(4, 32'h02, "R5 event wins over clear");

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 21));
      cyc($urandom_range(0, 1) == 1, a, $urandom, $urandom & $urandom);
      chk_irq("R6 sweep irq");
      a = AW'($urandom_range(0, 23));
      chk_rd(a, mread(a), "R8 sweep read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule